// File: doc/BRIEF.md
# Asynchronous HDLC Receive Deframer with Frame Counter

This block sits behind a byte receiver on an asynchronous HDLC link. It takes the raw received byte stream and hands out frame payloads as a stream of bytes with a valid strobe and an end-of-frame marker. It locates frame boundaries from flag bytes (0x7E), removes the escape byte (0x7D), and restores the byte that follows an escape. Before any of this, it can drop any raw control character in the range 0x00 to 0x1F by setting that character's bit in a 32-bit drop mask.

Each completed, non-empty frame raises a one-cycle end strobe. A counter counts these frames and raises a one-cycle event once a programmable threshold is reached, and then starts again from zero. An escape followed directly by a flag is an abort: the block raises an abort strobe, drops the partial frame and does not count it. Frame check sequences, serial-to-byte conversion and payload storage belong to other blocks.

Top module: `hdlc_async_rx_deframer`

## Requirements
- R1: A 0x7E byte closes the open frame. The last payload byte leaves with `pl_last` high, in the cycle after the clock edge that accepted the closing flag. Every other payload byte leaves in the cycle after the edge that accepted the next non-discarded data byte.
- R2: A raw byte c in the range 0x00 to 0x1F whose mask bit c (counted from bit 0) is set is dropped. It produces no output and no strobe, and it leaves the escape state unchanged.
- R3: A byte in the range 0x00 to 0x1F whose mask bit is clear passes through as payload. An all-zero mask drops nothing.
- R4: A 0x7D byte is removed, and the next accepted byte other than 0x7E is emitted XORed with 0x20.
- R5: Back-to-back flags create no empty frame: no payload, no end strobe, no count.
- R6: 0x7D followed directly by 0x7E pulses `abort_strb` for one cycle. The byte still pending is dropped, no end strobe occurs, the frame is not counted, and that 0x7E opens the next frame.
- R7: `frame_end` pulses for one cycle together with each byte marked `pl_last`.
- R8: `frames_evt` pulses together with the `frame_end` of the frame that brings the count of completed frames up to `frame_thresh`. The count then restarts at zero.
- R9: A `frame_thresh` of zero acts as one, so every completed frame pulses `frames_evt`.
- R10: After reset, every byte before the first 0x7E is ignored.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A raw received byte is present |
| rx_byte | input | 8 | Raw received byte |
| drop_mask | input | 32 | Bit c set drops raw control character c |
| frame_thresh | input | 16 | Completed frames per event (0 acts as 1) |
| pl_valid | output | 1 | Payload byte valid |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Payload byte is the last of its frame |
| frame_end | output | 1 | A non-empty frame completed |
| abort_strb | output | 1 | An abort sequence was received |
| frames_evt | output | 1 | Frame count reached the threshold |

## Verification
The bench targets a dropped control byte that falls between an escape and the escaped byte. A design that let dropped bytes clear the escape would emit 0x43 where 0x63 is due. Mask bits 0 and 31 are tested so that an off-by-one in mask indexing shows up as a missing or extra byte. Abort is tested with a pending byte, so a design that flushes that byte as last, or that counts the aborted frame, shows a stray `pl_last`, `frame_end` or an early event. Flag pairs, garbage before the first flag, and thresholds of zero and three expose empty frames, false starts and counters that reset at the wrong time.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_BYTE  = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_XOR   = 8'h20;
endpackage

// File: rtl/hdlc_rx_ctl_filter.sv
module hdlc_rx_ctl_filter #(
  parameter int MASK_W = 32
) (
  input  logic                            rx_valid,
  input  logic [hdlc_rx_pkg::BYTE_W-1:0]  rx_byte,
  input  logic [MASK_W-1:0]               drop_mask,
  output logic                            acc_valid
);
  localparam int IDX_W = $clog2(MASK_W);

  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range  = (rx_byte >> IDX_W) == '0;
  assign idx       = rx_byte[IDX_W-1:0];
  assign acc_valid = rx_valid && !(in_range && drop_mask[idx]);
endmodule

// File: rtl/hdlc_rx_unstuff.sv
module hdlc_rx_unstuff
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [BYTE_W-1:0] acc_byte,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_data,
  output logic              pl_last,
  output logic              frame_end,
  output logic              abort_strb,
  output logic              done_now
);
  logic              hunting, esc, have_hold;
  logic [BYTE_W-1:0] hold;
  logic              n_hunting, n_esc, n_have_hold;
  logic [BYTE_W-1:0] n_hold;
  logic              n_valid, n_last, n_end, n_abort;
  logic [BYTE_W-1:0] n_data;

  always_comb begin
    n_hunting   = hunting;
    n_esc       = esc;
    n_have_hold = have_hold;
    n_hold      = hold;
    n_valid     = 1'b0;
    n_data      = pl_data;
    n_last      = 1'b0;
    n_end       = 1'b0;
    n_abort     = 1'b0;
    if (acc_valid) begin
      if (acc_byte == FLAG_BYTE) begin
        if (hunting) begin
          n_hunting = 1'b0;
        end else if (esc) begin
          n_abort     = 1'b1;
          n_esc       = 1'b0;
          n_have_hold = 1'b0;
        end else if (have_hold) begin
          n_valid     = 1'b1;
          n_data      = hold;
          n_last      = 1'b1;
          n_end       = 1'b1;
          n_have_hold = 1'b0;
        end
      end else if (!hunting) begin
        if (acc_byte == ESC_BYTE && !esc) begin
          n_esc = 1'b1;
        end else begin
          if (have_hold) begin
            n_valid = 1'b1;
            n_data  = hold;
          end
          n_hold      = esc ? (acc_byte ^ ESC_XOR) : acc_byte;
          n_have_hold = 1'b1;
          n_esc       = 1'b0;
        end
      end
    end
  end

  assign done_now = n_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting    <= 1'b1;
      esc        <= 1'b0;
      have_hold  <= 1'b0;
      hold       <= '0;
      pl_valid   <= 1'b0;
      pl_data    <= '0;
      pl_last    <= 1'b0;
      frame_end  <= 1'b0;
      abort_strb <= 1'b0;
    end else begin
      hunting    <= n_hunting;
      esc        <= n_esc;
      have_hold  <= n_have_hold;
      hold       <= n_hold;
      pl_valid   <= n_valid;
      pl_data    <= n_data;
      pl_last    <= n_last;
      frame_end  <= n_end;
      abort_strb <= n_abort;
    end
  end

  // R1: a last marker never appears without a valid byte
  a_r1_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    pl_last |-> pl_valid);
  // R6: abort and frame completion are exclusive, and an abort emits nothing
  a_r6_abort_exclusive: assert property (@(posedge clk) disable iff (rst)
    abort_strb |-> (!frame_end && !pl_valid));
  // R10: while hunting, a non-flag byte produces no output
  a_r10_hunt_silent: assert property (@(posedge clk) disable iff (rst)
    (hunting && acc_valid && acc_byte != FLAG_BYTE) |=> !pl_valid);
  // R5: a flag with nothing pending ends no frame
  a_r5_no_empty_frame: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_byte == FLAG_BYTE && !have_hold) |=> !frame_end);
endmodule

// File: rtl/hdlc_rx_frame_counter.sv
module hdlc_rx_frame_counter #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_now,
  input  logic [THR_W-1:0] frame_thresh,
  output logic             frames_evt
);
  logic [THR_W-1:0] cnt;
  logic [THR_W:0]   cnt_inc;
  logic [THR_W:0]   thr_eff;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign thr_eff = (frame_thresh == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, frame_thresh};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      frames_evt <= 1'b0;
    end else begin
      frames_evt <= 1'b0;
      if (done_now) begin
        if (cnt_inc >= thr_eff) begin
          cnt        <= '0;
          frames_evt <= 1'b1;
        end else begin
          cnt <= cnt_inc[THR_W-1:0];
        end
      end
    end
  end

  // R8: an event only follows a completed frame
  a_r8_evt_needs_frame: assert property (@(posedge clk) disable iff (rst)
    frames_evt |-> $past(done_now));
  // R8: the count restarts after an event
  a_r8_count_restarts: assert property (@(posedge clk) disable iff (rst)
    frames_evt |-> (cnt == '0));
endmodule

// File: rtl/hdlc_async_rx_deframer.sv
module hdlc_async_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MASK_W = 32,
  parameter int THR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [MASK_W-1:0] drop_mask,
  input  logic [THR_W-1:0]  frame_thresh,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_data,
  output logic              pl_last,
  output logic              frame_end,
  output logic              abort_strb,
  output logic              frames_evt
);
  logic acc_valid;
  logic done_now;

  hdlc_rx_ctl_filter #(.MASK_W(MASK_W)) u_filter (
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .drop_mask(drop_mask),
    .acc_valid(acc_valid)
  );

  hdlc_rx_unstuff u_unstuff (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_byte  (rx_byte),
    .pl_valid  (pl_valid),
    .pl_data   (pl_data),
    .pl_last   (pl_last),
    .frame_end (frame_end),
    .abort_strb(abort_strb),
    .done_now  (done_now)
  );

  hdlc_rx_frame_counter #(.THR_W(THR_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .done_now    (done_now),
    .frame_thresh(frame_thresh),
    .frames_evt  (frames_evt)
  );

  // R2: a dropped raw byte leaves every output quiet in the next cycle
  a_r2_drop_is_silent: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !acc_valid) |=> (!pl_valid && !frame_end && !abort_strb));
  // R7: the end strobe accompanies exactly the byte marked last
  a_r7_end_with_last: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (pl_valid && pl_last));
endmodule

// File: tb/hdlc_async_rx_deframer_tb.sv
module hdlc_async_rx_deframer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [31:0] drop_mask = '0;
  logic [15:0] frame_thresh = '0;
  logic        pl_valid, pl_last, frame_end, abort_strb, frames_evt;
  logic [7:0]  pl_data;

  always #5 clk = ~clk;

  hdlc_async_rx_deframer u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .drop_mask(drop_mask), .frame_thresh(frame_thresh),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
    .frame_end(frame_end), .abort_strb(abort_strb), .frames_evt(frames_evt)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  bit        m_hunt = 1'b1;
  bit        m_esc = 1'b0;
  logic [7:0] m_pend[$];
  int        m_frames = 0;
  bit        e_v, e_l, e_end, e_ab, e_ev;
  logic [7:0] e_d;
  string     tag = "R11";

  task automatic model_step(input bit v, input logic [7:0] b);
    logic [7:0] d;
    int thr;
    e_v = 0; e_l = 0; e_end = 0; e_ab = 0; e_ev = 0; e_d = 8'h00;
    if (!v) return;
    if (b < 8'd32 && drop_mask[b[4:0]]) return;
    if (b == 8'h7E) begin
      if (m_hunt) m_hunt = 0;
      else if (m_esc) begin
        e_ab = 1; m_esc = 0; m_pend.delete();
      end else if (m_pend.size() > 0) begin
        e_v = 1; e_d = m_pend.pop_front(); e_l = 1; e_end = 1;
        m_frames++;
        thr = (frame_thresh == 0) ? 1 : int'(frame_thresh);
        if (m_frames >= thr) begin e_ev = 1; m_frames = 0; end
      end
    end else if (!m_hunt) begin
      if (b == 8'h7D && !m_esc) m_esc = 1;
      else begin
        d = m_esc ? (b ^ 8'h20) : b;
        m_esc = 0;
        if (m_pend.size() > 0) begin e_v = 1; e_d = m_pend.pop_front(); end
        m_pend.push_back(d);
      end
    end
  endtask

  task automatic compare();
    compared++;
    if (pl_valid !== e_v || (e_v && pl_data !== e_d) || pl_last !== e_l ||
        frame_end !== e_end || abort_strb !== e_ab || frames_evt !== e_ev) begin
      mismatched++;
      $display("FAIL %s t=%0t actual v=%0b d=%02h l=%0b end=%0b ab=%0b ev=%0b expected v=%0b d=%02h l=%0b end=%0b ab=%0b ev=%0b",
               tag, $time, pl_valid, pl_data, pl_last, frame_end, abort_strb, frames_evt,
               e_v, e_d, e_l, e_end, e_ab, e_ev);
    end
  endtask

  // one clock: check what the previous edge produced, then drive the next input
  task automatic cyc(input bit v, input logic [7:0] b);
    @(negedge clk);
    compare();
    model_step(v, b);
    rx_valid = v;
    rx_byte  = b;
  endtask

  task automatic send(input logic [7:0] b);
    cyc(1'b1, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    e_v = 0; e_l = 0; e_end = 0; e_ab = 0; e_ev = 0; e_d = 0;
    // R11: reset state
    tag = "R11";
    repeat (3) begin @(negedge clk); compare(); end
    rst = 1'b0;
    idle(2);

    // R10: bytes before the first flag are ignored
    tag = "R10";
    send(8'h41); send(8'h7D); send(8'h42); idle(1);

    // R1, R7, R9: basic frame, threshold zero acts as one
    tag = "R1";
    send(8'h7E); send(8'h41); send(8'h42); send(8'h43); send(8'h7E);
    tag = "R9"; idle(2);
    tag = "R7";
    send(8'h55); idle(1); send(8'h7E); idle(1);

    // R5: back-to-back flags
    tag = "R5";
    send(8'h7E); send(8'h7E); send(8'h7E); idle(1);

    // R4: escapes
    tag = "R4";
    send(8'h10); send(8'h7D); send(8'h5E); send(8'h7D); send(8'h5D);
    send(8'h7D); send(8'h7D); send(8'h7E); idle(1);

    // R3: zero mask passes control characters
    tag = "R3";
    send(8'h01); send(8'h00); send(8'h1F); send(8'h7E); idle(1);

    // R2: dropped bytes, including between escape and escaped byte
    tag = "R2";
    drop_mask = (32'h1 << 8'h11) | (32'h1 << 8'h13);
    send(8'h41); send(8'h11); send(8'h42); send(8'h7D); send(8'h13);
    send(8'h43); send(8'h13); send(8'h7E); idle(1);
    drop_mask = 32'h8000_0001;
    send(8'h00); send(8'h1F); send(8'h20); send(8'h1E); send(8'h00); send(8'h7E); idle(1);
    drop_mask = '0;

    // R6: abort with a pending byte, then a good frame
    tag = "R6";
    send(8'h44); send(8'h45); send(8'h7D); send(8'h7E); idle(1);
    send(8'h46); send(8'h7E); idle(1);
    send(8'h7D); send(8'h7E); send(8'h7E); idle(1);

    // R8: threshold of three, abort not counted
    tag = "R8";
    frame_thresh = 16'd3;
    for (int f = 0; f < 7; f++) begin
      send(8'h30 + 8'(f)); send(8'h31);
      if (f == 3) begin send(8'h7D); send(8'h7E); end
      else send(8'h7E);
      idle(1);
    end

    // mixed traffic checked cycle by cycle
    tag = "R1";
    drop_mask = (32'h1 << 8'h11) | (32'h1 << 8'h05);
    frame_thresh = 16'd2;
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 9);
      case (r)
        0: b = 8'h7E;
        1: b = 8'h7D;
        2: b = 8'h11;
        3: b = 8'h05;
        4: b = 8'h5E;
        default: b = 8'($urandom_range(0, 255));
      endcase
      cyc(($urandom_range(0, 3) != 0), b);
    end
    idle(3);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule